// File: doc/BRIEF.md
# Sound Generator Write Decoder and Tone Dividers

This block is the byte-wide programming front end of a four-voice sound generator. A host writes single bytes. A byte with its top bit set is a latch byte. It picks one of eight internal registers and loads that register's low nibble. A byte with its top bit clear is a data byte. It carries more bits into whichever register was latched most recently. The eight registers are three 10-bit tone periods, four 4-bit attenuations and one 4-bit noise control word.

The three tone periods drive three square-wave dividers, which this block contains. The noise control word, a one-cycle noise-shifter reset strobe and the effective period of tone voice 2 are handed to the downstream noise and mixing logic. A free-running prescaler makes the divided tick that paces every voice.

The write port has no back-pressure. A write strobe and a byte are taken in the same cycle, and every strobed byte is accepted. `ready` is an advisory status pin: it is low from the cycle after a write until one divided tick has passed. Writes that arrive while it is low are still applied.

Three parameters select the variant:
- `ZERO_AS_MAX` decides how a zero period is treated.
- `STRICT_DATA` selects the stricter data-byte filtering and the mode-change-only noise reset.
- `PTR_INIT` sets the register pointer after reset.

Top module: `psg_write_front`

## Requirements
- R1: A byte with bit 7 set selects register index bits 6:4 and stores that index as the pointer. Indices 0, 2 and 4 are the periods of tones 0, 1 and 2. Indices 1, 3, 5 and 7 are the attenuations of voices 0 to 3, output on `atten_all` bits 3:0, 7:4, 11:8 and 15:12. Index 6 is the noise control word. Bits 3:0 of the byte replace the period's bits 3:0 or the whole 4-bit value.
- R2: A byte with bit 7 clear, when the pointer names a tone period, replaces period bits 9:4 with byte bits 5:0 and keeps bits 3:0.
- R3: A byte with bit 7 clear, when the pointer names an attenuation or the noise word, replaces that 4-bit value with byte bits 3:0, provided `STRICT_DATA`=0.
- R4: After reset, the pointer equals `PTR_INIT`: 0 by default, 3 in the variant that boots pointing at voice 1 attenuation.
- R5: With `STRICT_DATA`=0, every write that reaches index 6 (latch or data) raises `lfsr_rst` for exactly the one cycle after the write. No other write raises it.
- R6: With `STRICT_DATA`=1, data bytes aimed at indices 1, 3, 5, 6 or 7 change nothing. A latch to index 6 raises `lfsr_rst` only when byte bit 2 differs from the stored noise word's bit 2.
- R7: A stored period of zero acts as 0x400 when `ZERO_AS_MAX`=1 and as 0 when `ZERO_AS_MAX`=0. With a period of 0, the voice toggles on every tick. `ch2_period` shows the effective value for voice 2.
- R8: On each divided tick, each tone counter decrements. When it reaches zero or below, the wave toggles and the counter reloads the period. A steady period P≥1 therefore gives a half-cycle of P ticks.
- R9: `div_tick` is high for one cycle in every `DIV` clock cycles (every cycle when `DIV`=1).
- R10: `ready` goes low in the cycle after a write. It returns high in the cycle after the first `div_tick` pulse seen after the write cycle.
- R11: Writes issued while `ready` is low are applied normally.
- R12: Reset clears every register and wave. It leaves `ready` high and `lfsr_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, byte taken this cycle |
| wr_data | input | 8 | Latch or data byte |
| ready | output | 1 | Low while a write is settling (advisory) |
| div_tick | output | 1 | Divided tick pulse |
| tone_wave | output | 3 | Square waves of tones 2..0 |
| atten_all | output | 16 | Attenuations of voices 3..0, 4 bits each |
| noise_ctrl | output | 4 | Noise control word |
| lfsr_rst | output | 1 | One-cycle noise shifter reset strobe |
| ch2_period | output | 11 | Effective period of tone voice 2 |

## Verification
The hardest state to reach from the ports is the strict variant's noise reset, which depends on the stored mode bit. The stimulus therefore runs latches to index 6 that alternately flip and repeat bit 2, and then a data byte aimed at index 6 that must be dropped.

A period of zero in the default variant means 1024 ticks per half-wave. The bench lets that voice run from reset and times a full settled half-cycle.

The `ready` recovery is checked against the observed `div_tick` pulses rather than a fixed delay. That keeps it correct wherever the write lands in the prescaler phase.

// File: rtl/psg_wr_pkg.sv
package psg_wr_pkg;
  localparam int NREG      = 8;
  localparam int IDXW      = 3;
  localparam int PER_W     = 10;
  localparam int EFF_W     = PER_W + 1;
  localparam int NTONE     = 3;
  localparam int NVOICE    = 4;
  localparam logic [IDXW-1:0] IDX_NOISE = 3'd6;

  function automatic logic idx_is_tone(input logic [IDXW-1:0] idx);
    return (idx[0] == 1'b0) && (idx != IDX_NOISE);
  endfunction

  function automatic logic idx_is_atten(input logic [IDXW-1:0] idx);
    return idx[0];
  endfunction
endpackage

// File: rtl/psg_tick_gen.sv
module psg_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= 1'b1;
      end
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= CW'(DIV - 1);
          tick  <= 1'b0;
        end else begin
          tick  <= (cnt_q == '0);
          cnt_q <= (cnt_q == '0) ? CW'(DIV - 1) : cnt_q - 1'b1;
        end
      end

      // two ticks are never adjacent when dividing
      p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
  import psg_wr_pkg::*;
#(
  parameter bit ZERO_AS_MAX = 1'b1,
  parameter bit STRICT_DATA = 1'b0,
  parameter int PTR_INIT    = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  output logic [NTONE*EFF_W-1:0]   period_eff,
  output logic [NVOICE*4-1:0]      atten_all,
  output logic [3:0]               noise_ctrl,
  output logic                     lfsr_rst
);
  logic [NTONE-1:0][PER_W-1:0] per_q;
  logic [NVOICE-1:0][3:0]      att_q;
  logic [3:0]                  noise_q;
  logic [IDXW-1:0]             ptr_q;

  logic            is_latch;
  logic [IDXW-1:0] tgt;
  logic            drop;
  logic [1:0]      slot;

  always_comb begin
    is_latch = wr_data[7];
    tgt      = is_latch ? wr_data[6:4] : ptr_q;
    slot     = tgt[2:1];
    drop     = STRICT_DATA && !is_latch && (tgt[0] || (tgt == IDX_NOISE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= '0;
      att_q    <= '0;
      noise_q  <= '0;
      ptr_q    <= IDXW'(PTR_INIT);
      lfsr_rst <= 1'b0;
    end else begin
      lfsr_rst <= 1'b0;
      if (wr_en) begin
        if (is_latch) ptr_q <= wr_data[6:4];
        if (!drop) begin
          if (idx_is_tone(tgt)) begin
            if (is_latch) per_q[slot][3:0]       <= wr_data[3:0];
            else          per_q[slot][PER_W-1:4] <= wr_data[5:0];
          end else if (idx_is_atten(tgt)) begin
            att_q[slot] <= wr_data[3:0];
          end else begin
            noise_q  <= wr_data[3:0];
            lfsr_rst <= STRICT_DATA ? (wr_data[2] != noise_q[2]) : 1'b1;
          end
        end
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NTONE; gi++) begin : g_eff
      always_comb begin
        if (per_q[gi] == '0)
          period_eff[gi*EFF_W +: EFF_W] = ZERO_AS_MAX ? EFF_W'(1 << PER_W) : '0;
        else
          period_eff[gi*EFF_W +: EFF_W] = {1'b0, per_q[gi]};
      end
    end
  endgenerate

  assign atten_all  = att_q;
  assign noise_ctrl = noise_q;

  p_strobe_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_rst |-> $past(wr_en));

  p_latch_sets_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> (ptr_q == $past(wr_data[6:4])));

  generate
    if (STRICT_DATA) begin : g_strict_chk
      p_filtered_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && (ptr_q[0] || ptr_q == IDX_NOISE))
          |=> ($stable(att_q) && $stable(noise_q) && !lfsr_rst));
    end
  endgenerate
endmodule

// File: rtl/psg_square.sv
module psg_square #(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          wave
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wave  <= 1'b0;
    end else if (tick) begin
      if (cnt_q <= PW'(1)) begin
        wave  <= ~wave;
        cnt_q <= period;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_wave_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave));
endmodule

// File: rtl/psg_write_front.sv
module psg_write_front
  import psg_wr_pkg::*;
#(
  parameter int DIV         = 8,
  parameter bit ZERO_AS_MAX = 1'b1,
  parameter bit STRICT_DATA = 1'b0,
  parameter int PTR_INIT    = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic        ready,
  output logic        div_tick,
  output logic [2:0]  tone_wave,
  output logic [15:0] atten_all,
  output logic [3:0]  noise_ctrl,
  output logic        lfsr_rst,
  output logic [10:0] ch2_period
);
  logic [NTONE*EFF_W-1:0] period_eff;
  logic                   busy_q;

  psg_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (div_tick)
  );

  psg_reg_bank #(
    .ZERO_AS_MAX(ZERO_AS_MAX),
    .STRICT_DATA(STRICT_DATA),
    .PTR_INIT   (PTR_INIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .period_eff(period_eff),
    .atten_all (atten_all),
    .noise_ctrl(noise_ctrl),
    .lfsr_rst  (lfsr_rst)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NTONE; gc++) begin : g_tone
      psg_square #(.PW(EFF_W)) u_sq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (div_tick),
        .period(period_eff[gc*EFF_W +: EFF_W]),
        .wave  (tone_wave[gc])
      );
    end
  endgenerate

  assign ch2_period = period_eff[2*EFF_W +: EFF_W];

  // a write in the same cycle as a tick keeps the block busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (wr_en)    busy_q <= 1'b1;
    else if (div_tick) busy_q <= 1'b0;
  end
  assign ready = ~busy_q;

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !ready);

  p_ready_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(div_tick));
endmodule

// File: tb/psg_write_front_test.sv
module psg_write_front_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic en_d = 1'b0, en_s = 1'b0, en_n = 1'b0;

  logic rdy_d, rdy_s, rdy_n, tk_d, tk_s, tk_n, lr_d, lr_s, lr_n;
  logic [2:0] wv_d, wv_s, wv_n;
  logic [15:0] at_d, at_s, at_n;
  logic [3:0] nz_d, nz_s, nz_n;
  logic [10:0] c2_d, c2_s, c2_n;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psg_write_front uut (
    .clk(clk), .rst_n(rst_n), .wr_en(en_d), .wr_data(wr_data), .ready(rdy_d),
    .div_tick(tk_d), .tone_wave(wv_d), .atten_all(at_d), .noise_ctrl(nz_d),
    .lfsr_rst(lr_d), .ch2_period(c2_d));

  psg_write_front #(.DIV(1), .ZERO_AS_MAX(1'b0), .STRICT_DATA(1'b0), .PTR_INIT(3)) uut_s (
    .clk(clk), .rst_n(rst_n), .wr_en(en_s), .wr_data(wr_data), .ready(rdy_s),
    .div_tick(tk_s), .tone_wave(wv_s), .atten_all(at_s), .noise_ctrl(nz_s),
    .lfsr_rst(lr_s), .ch2_period(c2_s));

  psg_write_front #(.DIV(8), .ZERO_AS_MAX(1'b1), .STRICT_DATA(1'b1), .PTR_INIT(0)) uut_n (
    .clk(clk), .rst_n(rst_n), .wr_en(en_n), .wr_data(wr_data), .ready(rdy_n),
    .div_tick(tk_n), .tone_wave(wv_n), .atten_all(at_n), .noise_ctrl(nz_n),
    .lfsr_rst(lr_n), .ch2_period(c2_n));

  // byte, atten_all, noise_ctrl, ch2_period, lfsr_rst  (default variant, R1 R2 R3 R5 R7)
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {8'h9A, 16'h000A, 4'h0, 11'h400, 1'b0},
    {8'h05, 16'h0005, 4'h0, 11'h400, 1'b0},
    {8'hFF, 16'hF005, 4'h0, 11'h400, 1'b0},
    {8'hC3, 16'hF005, 4'h0, 11'h003, 1'b0},
    {8'h2A, 16'hF005, 4'h0, 11'h2A3, 1'b0},
    {8'hE5, 16'hF005, 4'h5, 11'h2A3, 1'b1},
    {8'h01, 16'hF005, 4'h1, 11'h2A3, 1'b1},
    {8'hB7, 16'hF075, 4'h1, 11'h2A3, 1'b0},
    {8'hD2, 16'hF275, 4'h1, 11'h2A3, 1'b0},
    {8'hC0, 16'hF275, 4'h1, 11'h2A0, 1'b0},
    {8'h00, 16'hF275, 4'h1, 11'h400, 1'b0},
    {8'h7F, 16'hF275, 4'h1, 11'h3F0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inst: 0 default, 1 boot-at-3 variant, 2 strict variant
  task automatic wr(input int inst, input logic [7:0] b);
    @(negedge clk);
    wr_data = b;
    en_d = (inst == 0); en_s = (inst == 1); en_n = (inst == 2);
    @(negedge clk);
    en_d = 1'b0; en_s = 1'b0; en_n = 1'b0;
  endtask

  function automatic logic pick(input int inst, input int ch);
    case (inst)
      0: return wv_d[ch];
      1: return wv_s[ch];
      default: return wv_n[ch];
    endcase
  endfunction

  task automatic half_period(input int inst, input int ch, output int cycles);
    logic p, w;
    p = pick(inst, ch);
    for (int e = 0; e < 2; e++) begin
      do begin @(negedge clk); w = pick(inst, ch); end while (w == p);
      p = w;
    end
    cycles = 0;
    do begin @(negedge clk); cycles++; w = pick(inst, ch); end while (w == p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12 atten", at_d, 16'h0);
    chk("R12 noise", nz_d, 4'h0);
    chk("R12 wave", wv_d, 3'b000);
    chk("R12 ready", rdy_d, 1'b1);
    chk("R12 lfsr_rst", lr_d, 1'b0);
    chk("R12 ch2 zero-as-0", c2_s, 11'h000);

    // R4 boot pointer 3 -> data byte lands in voice 1 attenuation
    wr(1, 8'h05);
    chk("R4 ptr init 3", at_s, 16'h0050);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(0, VEC[i][39:32]);
      chk($sformatf("R1/R2/R3 row%0d atten", i), at_d, VEC[i][31:16]);
      chk($sformatf("R3/R5 row%0d noise", i), nz_d, VEC[i][15:12]);
      chk($sformatf("R2/R7 row%0d ch2", i), c2_d, VEC[i][11:1]);
      chk($sformatf("R5 row%0d strobe", i), lr_d, VEC[i][0]);
    end

    // R5 strobe lasts one cycle
    wr(0, 8'hE2);
    @(negedge clk);
    chk("R5 strobe one cycle", lr_d, 1'b0);

    // R10 ready behaviour against observed ticks
    repeat (20) @(negedge clk);
    chk("R10 ready idle", rdy_d, 1'b1);
    wr(0, 8'h9F);
    chk("R10 ready low after write", rdy_d, 1'b0);
    ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      if (tk_d) begin
        @(negedge clk);
        if (rdy_d !== 1'b1) ok = 1'b0;
        break;
      end
      @(negedge clk);
      if (!tk_d && rdy_d !== 1'b0) ok = 1'b0;
    end
    chk("R10 ready recovers after tick", ok, 1'b1);

    // R11 back-to-back writes while not ready
    wr(0, 8'h93);
    chk("R11 ready low", rdy_d, 1'b0);
    wr(0, 8'h9C);
    chk("R11 second write applied", at_d, 16'hF27C);

    // R9 tick spacing
    while (!tk_d) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!tk_d);
    chk("R9 tick spacing div8", n, 8);
    @(negedge clk);
    chk("R9 tick every cycle div1", tk_s, 1'b1);
    @(negedge clk);
    chk("R9 tick every cycle div1 again", tk_s, 1'b1);

    // R8 tone half-cycle: period 3 at div 8
    wr(0, 8'h83);
    wr(0, 8'h00);
    half_period(0, 0, n);
    chk("R8 half period 3", n, 24);
    // R8 period 5 at div 1
    wr(1, 8'hA5);
    half_period(1, 1, n);
    chk("R8 half period 5", n, 5);
    // R7 zero period as zero: toggle each tick
    wr(1, 8'h80);
    half_period(1, 0, n);
    chk("R7 zero period toggles every tick", n, 1);
    wr(1, 8'hC0);
    chk("R7 ch2 zero", c2_s, 11'h000);
    // R7 zero period as 0x400 (voice 1 untouched since reset)
    half_period(0, 1, n);
    chk("R7 zero as 0x400", n, 8192);

    // R6 strict variant
    wr(2, 8'hE4);
    chk("R6 mode flip noise", nz_n, 4'h4);
    chk("R6 mode flip strobe", lr_n, 1'b1);
    wr(2, 8'hE5);
    chk("R6 same mode noise", nz_n, 4'h5);
    chk("R6 same mode no strobe", lr_n, 1'b0);
    wr(2, 8'hE1);
    chk("R6 mode flip back strobe", lr_n, 1'b1);
    wr(2, 8'h0F);
    chk("R6 data to noise ignored", nz_n, 4'h1);
    chk("R6 data to noise no strobe", lr_n, 1'b0);
    wr(2, 8'h93);
    wr(2, 8'h08);
    chk("R6 data to atten0 ignored", at_n, 16'h0003);
    wr(2, 8'hFA);
    wr(2, 8'h02);
    chk("R6 data to atten3 ignored", at_n, 16'hA003);
    wr(2, 8'hC5);
    wr(2, 8'h02);
    chk("R6 data to tone accepted", c2_n, 11'h025);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule